// File: doc/BRIEF.md
# Maskable interrupt priority controller

This block decides, for a small processor core, whether a maskable interrupt is taken at an instruction boundary and which source is taken. Every source has a pending bit and a 3-bit priority level. Hardware request pulses set the pending bits. Software can cancel a request by writing 0 to its pending bit. The core supplies its current processor priority level and reports each change it makes to the global interrupt-enable flag.

At each instruction-boundary strobe the controller looks at the eligible sources. A source is eligible when it is pending, has a nonzero level and its level is above the processor priority level. When the effective enable flag is 1 and at least one source is eligible, the controller grants the winner. The grant holds a request line to the core together with the source index and the source level. It keeps them until the core acknowledges the vector fetch, and that acknowledge clears the source's pending bit.

Enable-flag changes come in two kinds. A change made by a return-from-interrupt is used in the acceptance decision of that same instruction. A change made by a flag set, flag clear, flag pop or control-register load is used only from the next instruction's decision onward.

The controller runs a two-state machine:
- `ST_IDLE`: no grant is outstanding. The transition *accept* (boundary strobe, effective enable is 1, an eligible source exists) moves it to `ST_WAIT_ACK`.
- `ST_WAIT_ACK`: the request line is high. The transition *acknowledge* (`vec_ack` high) clears the granted pending bit and returns it to `ST_IDLE`. Boundary strobes that arrive in this state are ignored.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset all pending bits are 0, all source levels are 0, the enable flag is 0 and `irq_req` is 0.
- R2: A `src_req` pulse on a source sets its pending bit at that clock edge. This also holds when the same cycle carries a software clear of that bit or an acknowledge of that source.
- R3: A software write (`sw_wr_en` bit high) with data 0 clears that source's pending bit. A software write with data 1 is ignored: the bit is left as it was.
- R4: A source is eligible only when its pending bit is 1, its level is nonzero and its level is strictly greater than `core_ipl`.
- R5: Among eligible sources the one with the numerically highest level wins. When levels are equal, the lowest source index wins.
- R6: A grant is made only in a cycle where `insn_bound` is high, no grant is outstanding and the effective enable is 1. In the next cycle `irq_req` is 1, and `irq_idx`/`irq_lvl` hold the winner. All three stay unchanged until acknowledge, and boundary strobes in that time have no effect.
- R7: When `vec_ack` is high while `irq_req` is 1, the granted source's pending bit is cleared at that edge (unless R2 applies) and `irq_req` is 0 in the next cycle. `vec_ack` while `irq_req` is 0 has no effect.
- R8: A flag update with `flag_kind`=1 (return-from-interrupt kind) supplies `flag_val` as the effective enable for the decision in that same cycle.
- R9: A flag update with `flag_kind`=0 (set/clear/pop/load kind) leaves the decision of that cycle on the previous flag value. `int_en` takes `flag_val` at that edge, and it is used from the next decision on.
- R10: While the effective enable is 0, no grant is made, whatever requests are pending.
- R11: A level write (`lvl_wr_en` bit i high) loads bits [3i+2:3i] of `lvl_wr_data` as source i's level at that edge. The level used for a decision in a cycle is the value held before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_req | input | NUM_SRC | Hardware request pulses, one per source |
| sw_wr_en | input | NUM_SRC | Software write strobe to pending bits |
| sw_wr_pend | input | NUM_SRC | Software write data for pending bits (only 0 has an effect) |
| lvl_wr_en | input | NUM_SRC | Level write strobe per source |
| lvl_wr_data | input | NUM_SRC*LVL_W | Level write data, source i in bits [LVL_W*i +: LVL_W] |
| core_ipl | input | LVL_W | Processor priority level |
| flag_wr | input | 1 | Enable flag update pulse |
| flag_kind | input | 1 | 1 = return-from-interrupt kind (immediate), 0 = deferred kind |
| flag_val | input | 1 | New enable flag value |
| insn_bound | input | 1 | Instruction-boundary acceptance strobe |
| vec_ack | input | 1 | Core acknowledge of the vector fetch |
| irq_req | output | 1 | Interrupt request to the core |
| irq_idx | output | IDX_W | Granted source index |
| irq_lvl | output | LVL_W | Granted source level |
| int_en | output | 1 | Current enable flag |
| pend_o | output | NUM_SRC | Pending bits |

## Verification
The bench builds the controller with NUM_SRC=6 and LVL_W=3. With 6 sources the index field is 3 bits wide while indices 6 and 7 are never valid, and 6 sources give enough equal-level collisions to exercise tie breaking by index. The full 0..7 level and processor-level range is reachable, so the strict-greater boundary and level 0 are both covered. Random flag updates of both kinds arrive on boundary cycles as well as between boundaries, which exposes the difference between immediate and deferred enable timing.

// File: rtl/irq_pkg.sv
package irq_pkg;

    typedef enum logic {
        ST_IDLE     = 1'b0,
        ST_WAIT_ACK = 1'b1
    } irq_state_e;

    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
    parameter int NUM_SRC = 8,
    parameter int LVL_W   = 3,
    parameter int IDX_W   = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_SRC-1:0]       src_req,
    input  logic [NUM_SRC-1:0]       sw_wr_en,
    input  logic [NUM_SRC-1:0]       sw_wr_pend,
    input  logic [NUM_SRC-1:0]       lvl_wr_en,
    input  logic [NUM_SRC*LVL_W-1:0] lvl_wr_data,
    input  logic                     ack_clr,
    input  logic [IDX_W-1:0]         ack_idx,
    output logic [NUM_SRC-1:0]       pend_q,
    output logic [NUM_SRC*LVL_W-1:0] lvl_q
);

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        logic clr_sw;
        logic clr_ack;

        // only a written 0 cancels; a written 1 falls through
        assign clr_sw  = sw_wr_en[i] & ~sw_wr_pend[i];
        assign clr_ack = ack_clr & (ack_idx == IDX_W'(i));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pend_q[i] <= 1'b0;
            end else if (src_req[i]) begin
                pend_q[i] <= 1'b1;          // hardware set wins
            end else if (clr_sw || clr_ack) begin
                pend_q[i] <= 1'b0;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lvl_q[i*LVL_W +: LVL_W] <= '0;
            end else if (lvl_wr_en[i]) begin
                lvl_q[i*LVL_W +: LVL_W] <= lvl_wr_data[i*LVL_W +: LVL_W];
            end
        end

        assert_hw_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
            src_req[i] |=> pend_q[i]);

        assert_no_sw_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (!pend_q[i] && !src_req[i]) |=> !pend_q[i]);

        assert_sw_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (sw_wr_en[i] && !sw_wr_pend[i] && !src_req[i]) |=> !pend_q[i]);
    end

endmodule

// File: rtl/irq_prio_arb.sv
module irq_prio_arb #(
    parameter int NUM_SRC = 8,
    parameter int LVL_W   = 3,
    parameter int IDX_W   = 3
) (
    input  logic [NUM_SRC-1:0]       pend,
    input  logic [NUM_SRC*LVL_W-1:0] lvl,
    input  logic [LVL_W-1:0]         ipl,
    output logic                     found,
    output logic [IDX_W-1:0]         win_idx,
    output logic [LVL_W-1:0]         win_lvl
);

    logic [NUM_SRC-1:0] elig;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_elig
        assign elig[i] = pend[i]
                       && (lvl[i*LVL_W +: LVL_W] != '0)
                       && (lvl[i*LVL_W +: LVL_W] > ipl);
    end

    // scan from top index down; ">=" lets a lower index take over a tie
    always_comb begin
        found   = 1'b0;
        win_idx = '0;
        win_lvl = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (elig[i] && (!found || (lvl[i*LVL_W +: LVL_W] >= win_lvl))) begin
                found   = 1'b1;
                win_idx = IDX_W'(i);
                win_lvl = lvl[i*LVL_W +: LVL_W];
            end
        end
    end

endmodule

// File: rtl/irq_ien_ctrl.sv
module irq_ien_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic flag_wr,
    input  logic flag_kind,
    input  logic flag_val,
    output logic ien_q,
    output logic en_dec
);

    logic immediate;

    assign immediate = flag_wr & flag_kind;
    assign en_dec    = immediate ? flag_val : ien_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ien_q <= 1'b0;
        end else if (flag_wr) begin
            ien_q <= flag_val;
        end
    end

    assert_defer_update_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_wr && !flag_kind) |=> (ien_q == $past(flag_val)));

endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
    import irq_pkg::*;
#(
    parameter int NUM_SRC = 8,
    parameter int LVL_W   = 3,
    parameter int IDX_W   = irq_pkg::idx_width(NUM_SRC)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_SRC-1:0]       src_req,
    input  logic [NUM_SRC-1:0]       sw_wr_en,
    input  logic [NUM_SRC-1:0]       sw_wr_pend,
    input  logic [NUM_SRC-1:0]       lvl_wr_en,
    input  logic [NUM_SRC*LVL_W-1:0] lvl_wr_data,
    input  logic [LVL_W-1:0]         core_ipl,
    input  logic                     flag_wr,
    input  logic                     flag_kind,
    input  logic                     flag_val,
    input  logic                     insn_bound,
    input  logic                     vec_ack,
    output logic                     irq_req,
    output logic [IDX_W-1:0]         irq_idx,
    output logic [LVL_W-1:0]         irq_lvl,
    output logic                     int_en,
    output logic [NUM_SRC-1:0]       pend_o
);

    irq_state_e               state_q;
    irq_state_e               state_d;
    logic [NUM_SRC*LVL_W-1:0] lvl_all;
    logic                     en_dec;
    logic                     arb_found;
    logic [IDX_W-1:0]         arb_idx;
    logic [LVL_W-1:0]         arb_lvl;
    logic                     accept;
    logic                     ack_clr;
    logic [IDX_W-1:0]         g_idx_q;
    logic [LVL_W-1:0]         g_lvl_q;

    irq_pend_bank #(
        .NUM_SRC (NUM_SRC),
        .LVL_W   (LVL_W),
        .IDX_W   (IDX_W)
    ) u_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .src_req     (src_req),
        .sw_wr_en    (sw_wr_en),
        .sw_wr_pend  (sw_wr_pend),
        .lvl_wr_en   (lvl_wr_en),
        .lvl_wr_data (lvl_wr_data),
        .ack_clr     (ack_clr),
        .ack_idx     (g_idx_q),
        .pend_q      (pend_o),
        .lvl_q       (lvl_all)
    );

    irq_prio_arb #(
        .NUM_SRC (NUM_SRC),
        .LVL_W   (LVL_W),
        .IDX_W   (IDX_W)
    ) u_arb (
        .pend    (pend_o),
        .lvl     (lvl_all),
        .ipl     (core_ipl),
        .found   (arb_found),
        .win_idx (arb_idx),
        .win_lvl (arb_lvl)
    );

    irq_ien_ctrl u_ien (
        .clk       (clk),
        .rst_n     (rst_n),
        .flag_wr   (flag_wr),
        .flag_kind (flag_kind),
        .flag_val  (flag_val),
        .ien_q     (int_en),
        .en_dec    (en_dec)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state and strobes
    always_comb begin
        state_d = state_q;
        accept  = 1'b0;
        ack_clr = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (insn_bound && en_dec && arb_found) begin
                    accept  = 1'b1;
                    state_d = ST_WAIT_ACK;
                end
            end
            ST_WAIT_ACK: begin
                if (vec_ack) begin
                    ack_clr = 1'b1;
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // grant registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            g_idx_q <= '0;
            g_lvl_q <= '0;
        end else if (accept) begin
            g_idx_q <= arb_idx;
            g_lvl_q <= arb_lvl;
        end
    end

    assign irq_req = (state_q == ST_WAIT_ACK);
    assign irq_idx = g_idx_q;
    assign irq_lvl = g_lvl_q;

    assert_winner_eligible_R4: assert property (@(posedge clk) disable iff (!rst_n)
        arb_found |-> ((arb_lvl > core_ipl) && pend_o[arb_idx]));

    assert_req_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && !vec_ack) |=> (irq_req && $stable(irq_idx) && $stable(irq_lvl)));

    assert_grant_at_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_req) |-> $past(insn_bound));

    assert_ack_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && vec_ack && !src_req[irq_idx]) |=> (!pend_o[$past(irq_idx)] && !irq_req));

    assert_immediate_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_req && flag_wr && flag_kind && !flag_val) |=> !irq_req);

    assert_disabled_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_req && !int_en && !flag_wr) |=> !irq_req);

endmodule

// File: tb/irq_prio_ctrl_bench.sv
module irq_prio_ctrl_bench;

    localparam int CLK_PERIOD = 10;
    localparam int N  = 6;
    localparam int LW = 3;
    localparam int IW = 3;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [N-1:0]  i_src, i_swen, i_swval, i_lwen;
    logic [N*LW-1:0] i_lwdata;
    logic [LW-1:0] i_ipl;
    logic          i_fwr, i_fkind, i_fval, i_bound, i_ack;
    logic          o_req, o_en;
    logic [IW-1:0] o_idx;
    logic [LW-1:0] o_lvl;
    logic [N-1:0]  o_pend;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference model state
    logic [N-1:0]  m_pend;
    logic [LW-1:0] m_lvl [N];
    logic          m_ien;
    logic          m_busy;
    int            m_gidx;
    int            m_glvl;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_prio_ctrl #(.NUM_SRC(N), .LVL_W(LW)) u_irq_prio_ctrl (
        .clk(clk), .rst_n(rst_n), .src_req(i_src), .sw_wr_en(i_swen),
        .sw_wr_pend(i_swval), .lvl_wr_en(i_lwen), .lvl_wr_data(i_lwdata),
        .core_ipl(i_ipl), .flag_wr(i_fwr), .flag_kind(i_fkind), .flag_val(i_fval),
        .insn_bound(i_bound), .vec_ack(i_ack), .irq_req(o_req), .irq_idx(o_idx),
        .irq_lvl(o_lvl), .int_en(o_en), .pend_o(o_pend)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // ascending scan, strict greater: first (lowest) index keeps a tie
    function automatic int pick();
        int best = -1;
        int bl = 0;
        for (int i = 0; i < N; i++) begin
            if (m_pend[i] && m_lvl[i] != 0 && m_lvl[i] > i_ipl && int'(m_lvl[i]) > bl) begin
                best = i;
                bl = int'(m_lvl[i]);
            end
        end
        return best;
    endfunction

    task automatic quiet();
        i_src = '0; i_swen = '0; i_swval = '0; i_lwen = '0; i_lwdata = '0;
        i_fwr = 0; i_fkind = 0; i_fval = 0; i_bound = 0; i_ack = 0;
    endtask

    task automatic model_edge();
        logic en;
        int w;
        logic [N-1:0] clr;
        en = (i_fwr && i_fkind) ? i_fval : m_ien;
        clr = i_swen & ~i_swval;
        if (!m_busy) begin
            w = pick();
            if (i_bound && en && w >= 0) begin
                m_busy = 1; m_gidx = w; m_glvl = int'(m_lvl[w]);
            end
        end else if (i_ack) begin
            clr[m_gidx] = 1'b1;
            m_busy = 0;
        end
        m_pend = (m_pend & ~clr) | i_src;
        for (int i = 0; i < N; i++)
            if (i_lwen[i]) m_lvl[i] = i_lwdata[i*LW +: LW];
        if (i_fwr) m_ien = i_fval;
    endtask

    task automatic compare();
        chk("R2/R3/R7 pending", int'(o_pend), int'(m_pend));
        chk("R8/R9 int_en", int'(o_en), int'(m_ien));
        chk("R6/R10 irq_req", int'(o_req), int'(m_busy));
        if (m_busy) begin
            chk("R5 irq_idx", int'(o_idx), m_gidx);
            chk("R5/R11 irq_lvl", int'(o_lvl), m_glvl);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare();
        quiet();
    endtask

    task automatic set_lvl(input int s, input int v);
        i_lwen[s] = 1'b1;
        i_lwdata[s*LW +: LW] = LW'(v);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        void'($urandom(32'd20240611));
        quiet();
        i_ipl = '0;
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        m_pend = '0; m_ien = 0; m_busy = 0; m_gidx = 0; m_glvl = 0;
        for (int i = 0; i < N; i++) m_lvl[i] = '0;
        // R1: reset state
        chk("R1 pend", int'(o_pend), 0);
        chk("R1 int_en", int'(o_en), 0);
        chk("R1 irq_req", int'(o_req), 0);

        // R11: levels 3,5,5,0,2,7
        set_lvl(0, 3); set_lvl(1, 5); set_lvl(2, 5); set_lvl(3, 0); set_lvl(4, 2); set_lvl(5, 7);
        tick();
        // R10: pending source while enable 0, boundary -> no grant
        i_src[5] = 1; tick();
        i_bound = 1; tick();
        chk("R10 no grant when disabled", int'(o_req), 0);
        i_swen[5] = 1; i_swval[5] = 0; tick();
        chk("R3 write 0 clears", int'(o_pend[5]), 0);

        // R3: write 1 to an idle source is ignored
        i_swen[0] = 1; i_swval[0] = 1; tick();
        chk("R3 write 1 ignored", int'(o_pend[0]), 0);

        // R2: hardware set beats software clear
        i_src[0] = 1; i_swen[0] = 1; i_swval[0] = 0; tick();
        chk("R2 set wins", int'(o_pend[0]), 1);

        // enable via deferred kind, no boundary
        i_fwr = 1; i_fkind = 0; i_fval = 1; tick();

        // R4: level equal to ipl is not eligible; level 0 is not eligible
        i_ipl = 3'd3; i_src[3] = 1; tick();
        i_bound = 1; tick();
        chk("R4 level==ipl and level 0 rejected", int'(o_req), 0);
        i_ipl = 3'd2; i_bound = 1; tick();
        chk("R4 level>ipl accepted", int'(o_req), 1);
        chk("R4 idx", int'(o_idx), 0);
        i_ack = 1; tick();
        chk("R7 ack clears pending", int'(o_pend[0]), 0);
        chk("R7 req drops", int'(o_req), 0);
        i_swen[3] = 1; tick();

        // R5: tie at level 5 -> lowest index 1
        i_ipl = 3'd0; i_src[1] = 1; i_src[2] = 1; i_src[4] = 1; tick();
        i_bound = 1; tick();
        chk("R5 tie lowest index", int'(o_idx), 1);
        chk("R5 level", int'(o_lvl), 5);
        // R6: boundary while waiting ignored, outputs held
        i_src[5] = 1; i_bound = 1; tick();
        chk("R6 held idx", int'(o_idx), 1);
        i_ack = 1; tick();
        i_bound = 1; tick();
        chk("R5 highest level wins", int'(o_idx), 5);
        i_ack = 1; tick();

        // R9: deferred disable on a boundary still accepts
        i_fwr = 1; i_fkind = 0; i_fval = 0; i_bound = 1; tick();
        chk("R9 old value used", int'(o_req), 1);
        chk("R9 flag updated", int'(o_en), 0);
        i_ack = 1; tick();
        i_bound = 1; tick();
        chk("R9 new value used next", int'(o_req), 0);

        // R8: immediate enable on a boundary accepts at once
        i_fwr = 1; i_fkind = 1; i_fval = 1; i_bound = 1; tick();
        chk("R8 immediate enable", int'(o_req), 1);
        i_ack = 1; tick();
        // R8: immediate disable blocks the same decision
        i_fwr = 1; i_fkind = 1; i_fval = 0; i_bound = 1; tick();
        chk("R8 immediate disable", int'(o_req), 0);

        // constrained random
        for (int c = 0; c < 4000; c++) begin
            for (int i = 0; i < N; i++) begin
                i_src[i]  = ($urandom_range(0, 9) == 0);
                i_swen[i] = ($urandom_range(0, 11) == 0);
                i_swval[i] = 1'($urandom_range(0, 1));
                i_lwen[i] = ($urandom_range(0, 19) == 0);
            end
            i_lwdata = (N*LW)'({$urandom, $urandom});
            if ($urandom_range(0, 7) == 0) i_ipl = LW'($urandom_range(0, 7));
            i_fwr   = ($urandom_range(0, 7) == 0);
            i_fkind = 1'($urandom_range(0, 1));
            i_fval  = ($urandom_range(0, 3) != 0);
            i_bound = ($urandom_range(0, 2) == 0);
            i_ack   = ($urandom_range(0, 3) == 0);
            tick();
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule